// File: doc/BRIEF.md
# Global 64-bit Timer with Self-Advancing Comparator

This block keeps a 64-bit free-running count of timer clocks and one 64-bit compare channel. Software reaches it through a flat 32-bit register port with a word address, a write strobe, write data and combinational read data. The count is loaded as two 32-bit halves and counts only while its run bit is set. When the count equals the compare value and compare is enabled, a sticky match flag is raised. The interrupt line is that flag gated by an enable bit. With auto-advance switched on, each match adds a programmed 32-bit step to the compare value, so matches repeat at a fixed period without software rewriting the compare registers.

Every write to the counter halves, the compare halves, the step register or the control register is confirmed. A sticky write-done bit rises a fixed number of clocks after the write and stays set until software writes 1 to it. The counter halves are read separately and are not captured together. Software wanting a coherent 64-bit value reads high, low and high again, and retries if the two high reads differ.

Word map (`bus_addr`): 0 count low, 1 count high, 2 count write-done, 3 compare low, 4 compare high, 5 step, 6 control, 7 register write-done, 8 interrupt enable, 9 match flag. Control bits: 0 run, 1 compare enable, 2 auto-advance. Unmapped words read as zero.

Top module: `glb_cmp_timer`

## Requirements
- R1: After reset every register word (0 to 9) reads zero and `irq` is low.
- R2: While control bit 0 is set the count rises by exactly one per clock. While it is clear the count holds.
- R3: A write to word 0 or word 1 replaces that half of the count on the write's clock edge and takes priority over counting. The other half is kept.
- R4: When control bit 1 is set and the count equals the compare value, bit 0 of word 9 is set on the next clock edge. With control bit 1 clear, no match is flagged.
- R5: With control bits 1 and 2 set, each match adds the value of word 5 to the 64-bit compare value on the same edge that raises the flag. Matches therefore recur every step clocks.
- R6: `irq` is high exactly when bit 0 of word 9 and bit 0 of word 8 are both set.
- R7: Writing 1 to bit 0 of word 9 clears the match flag. Writing 0 leaves it unchanged.
- R8: Word 7 reports completed writes: compare low in bit 0, compare high in bit 1, step in bit 2, control in bit 16. Each bit is set ACK_DLY clocks after its write edge (default 2, range 1 to 3), stays set, and is cleared by writing 1 to it. Writing 0 leaves it unchanged.
- R9: Word 2 reports completed count writes, low half in bit 0 and high half in bit 1. Timing and clearing are as in R8.
- R10: A carry out of the low count half increments the high half in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Word address of the register access |
| bus_we | input | 1 | Write strobe, one write per clock |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Compare interrupt |

## Verification
The properties assume a write lasts a single clock with stable address and data. They also assume the count and compare registers change only through the port or through counting and auto-advance. The bench drives each write for one clock and leaves the strobe low otherwise. Auto-advance is exercised only with steps of three or more clocks. This keeps every flag clear finished before the next match can land and keeps each expected match time unambiguous. Counter and compare values are loaded only while the run bit is clear, except for the one case that checks load priority over counting.

// File: rtl/glb_tmr_pkg.sv
package glb_tmr_pkg;
  // word addresses
  localparam int REG_CNT_LO  = 0;
  localparam int REG_CNT_HI  = 1;
  localparam int REG_CNT_WST = 2;
  localparam int REG_CMP_LO  = 3;
  localparam int REG_CMP_HI  = 4;
  localparam int REG_STEP    = 5;
  localparam int REG_CTRL    = 6;
  localparam int REG_WST     = 7;
  localparam int REG_IEN     = 8;
  localparam int REG_ISTAT   = 9;

  // control bit positions
  localparam int CTL_RUN  = 0;
  localparam int CTL_CMP  = 1;
  localparam int CTL_AUTO = 2;

  // register write-done bit positions in the read image
  localparam int WST_CMP_LO = 0;
  localparam int WST_CMP_HI = 1;
  localparam int WST_STEP   = 2;
  localparam int WST_CTRL   = 16;

  typedef struct packed {
    logic auto_inc;
    logic cmp_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/glb_tmr_rst_sync.sv
module glb_tmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/glb_tmr_counter.sv
module glb_tmr_counter #(
  parameter int HALF_W = 32,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = run | wr_lo | wr_hi;
    if (wr_lo | wr_hi) begin
      if (wr_lo) cnt_d[HALF_W-1:0]     = wdata;
      if (wr_hi) cnt_d[CNT_W-1:HALF_W] = wdata;
    end else if (run) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/glb_tmr_compare.sv
module glb_tmr_compare #(
  parameter int HALF_W = 32,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              cmp_en,
  input  logic              auto_inc,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_step,
  input  logic [HALF_W-1:0] wdata,
  input  logic              flag_clr,
  output logic [CNT_W-1:0]  cmp,
  output logic [HALF_W-1:0] step,
  output logic              hit,
  output logic              flag
);
  logic [CNT_W-1:0]  cmp_q, cmp_d;
  logic [HALF_W-1:0] step_q;
  logic              flag_q, flag_d;
  logic              cmp_ce;

  assign hit = cmp_en & (cnt == cmp_q);

  always_comb begin
    cmp_d  = cmp_q;
    cmp_ce = wr_lo | wr_hi | (hit & auto_inc);
    if (wr_lo | wr_hi) begin
      if (wr_lo) cmp_d[HALF_W-1:0]     = wdata;
      if (wr_hi) cmp_d[CNT_W-1:HALF_W] = wdata;
    end else if (hit & auto_inc) begin
      cmp_d = cmp_q + {{HALF_W{1'b0}}, step_q};
    end
    flag_d = (flag_q & ~flag_clr) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      step_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (cmp_ce)  cmp_q  <= cmp_d;
      if (wr_step) step_q <= wdata;
      flag_q <= flag_d;
    end
  end

  assign cmp  = cmp_q;
  assign step = step_q;
  assign flag = flag_q;
endmodule

// File: rtl/glb_tmr_wack.sv
module glb_tmr_wack #(
  parameter int NB  = 4,
  parameter int DLY = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] wr,
  input  logic [NB-1:0] clr,
  output logic [NB-1:0] sts
);
  logic [NB-1:0] pipe_q [DLY];
  logic [NB-1:0] sts_q, sts_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q[0] <= '0;
    else        pipe_q[0] <= wr;
  end

  for (genvar k = 1; k < DLY; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q[k] <= '0;
      else        pipe_q[k] <= pipe_q[k-1];
    end
  end

  always_comb sts_d = (sts_q & ~clr) | pipe_q[DLY-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end

  assign sts = sts_q;
endmodule

// File: rtl/glb_cmp_timer.sv
module glb_cmp_timer
  import glb_tmr_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int ACK_DLY = 2,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int HALF_W = 32;
  localparam int CNT_W  = 2 * HALF_W;

  logic              rst_ni;
  ctrl_t             ctrl_q, ctrl_d;
  logic              ien_q, ien_d;
  logic [CNT_W-1:0]  cnt_q, cmp_q;
  logic [HALF_W-1:0] step_q;
  logic              hit, flag_q;
  logic [3:0]        wst_q;
  logic [1:0]        cwst_q;

  logic wr_cnt_lo, wr_cnt_hi, wr_cmp_lo, wr_cmp_hi, wr_step, wr_ctrl;
  logic wr_ien, wr_istat, wr_wst, wr_cwst;

  glb_tmr_rst_sync #(.STAGES(SYNC_N)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_no(rst_ni)
  );

  // write decode
  always_comb begin
    wr_cnt_lo = bus_we && (bus_addr == ADDR_W'(REG_CNT_LO));
    wr_cnt_hi = bus_we && (bus_addr == ADDR_W'(REG_CNT_HI));
    wr_cwst   = bus_we && (bus_addr == ADDR_W'(REG_CNT_WST));
    wr_cmp_lo = bus_we && (bus_addr == ADDR_W'(REG_CMP_LO));
    wr_cmp_hi = bus_we && (bus_addr == ADDR_W'(REG_CMP_HI));
    wr_step   = bus_we && (bus_addr == ADDR_W'(REG_STEP));
    wr_ctrl   = bus_we && (bus_addr == ADDR_W'(REG_CTRL));
    wr_wst    = bus_we && (bus_addr == ADDR_W'(REG_WST));
    wr_ien    = bus_we && (bus_addr == ADDR_W'(REG_IEN));
    wr_istat  = bus_we && (bus_addr == ADDR_W'(REG_ISTAT));
  end

  // control and enable registers
  always_comb begin
    ctrl_d = ctrl_q;
    ien_d  = ien_q;
    if (wr_ctrl) begin
      ctrl_d.run      = bus_wdata[CTL_RUN];
      ctrl_d.cmp_en   = bus_wdata[CTL_CMP];
      ctrl_d.auto_inc = bus_wdata[CTL_AUTO];
    end
    if (wr_ien) ien_d = bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ien_q  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_d;
      if (wr_ien)  ien_q  <= ien_d;
    end
  end

  glb_tmr_counter #(.HALF_W(HALF_W)) u_cnt (
    .clk(clk), .rst_n(rst_ni), .run(ctrl_q.run),
    .wr_lo(wr_cnt_lo), .wr_hi(wr_cnt_hi), .wdata(bus_wdata), .cnt(cnt_q)
  );

  glb_tmr_compare #(.HALF_W(HALF_W)) u_cmp (
    .clk(clk), .rst_n(rst_ni), .cnt(cnt_q),
    .cmp_en(ctrl_q.cmp_en), .auto_inc(ctrl_q.auto_inc),
    .wr_lo(wr_cmp_lo), .wr_hi(wr_cmp_hi), .wr_step(wr_step),
    .wdata(bus_wdata), .flag_clr(wr_istat & bus_wdata[0]),
    .cmp(cmp_q), .step(step_q), .hit(hit), .flag(flag_q)
  );

  // register write-done: index 3 ctrl, 2 step, 1 cmp hi, 0 cmp lo
  glb_tmr_wack #(.NB(4), .DLY(ACK_DLY)) u_wst (
    .clk(clk), .rst_n(rst_ni),
    .wr({wr_ctrl, wr_step, wr_cmp_hi, wr_cmp_lo}),
    .clr(wr_wst ? {bus_wdata[WST_CTRL], bus_wdata[WST_STEP],
                   bus_wdata[WST_CMP_HI], bus_wdata[WST_CMP_LO]} : 4'b0),
    .sts(wst_q)
  );

  glb_tmr_wack #(.NB(2), .DLY(ACK_DLY)) u_cwst (
    .clk(clk), .rst_n(rst_ni),
    .wr({wr_cnt_hi, wr_cnt_lo}),
    .clr(wr_cwst ? bus_wdata[1:0] : 2'b0),
    .sts(cwst_q)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(REG_CNT_LO):  bus_rdata = cnt_q[HALF_W-1:0];
      ADDR_W'(REG_CNT_HI):  bus_rdata = cnt_q[CNT_W-1:HALF_W];
      ADDR_W'(REG_CNT_WST): bus_rdata[1:0] = cwst_q;
      ADDR_W'(REG_CMP_LO):  bus_rdata = cmp_q[HALF_W-1:0];
      ADDR_W'(REG_CMP_HI):  bus_rdata = cmp_q[CNT_W-1:HALF_W];
      ADDR_W'(REG_STEP):    bus_rdata = step_q;
      ADDR_W'(REG_CTRL): begin
        bus_rdata[CTL_RUN]  = ctrl_q.run;
        bus_rdata[CTL_CMP]  = ctrl_q.cmp_en;
        bus_rdata[CTL_AUTO] = ctrl_q.auto_inc;
      end
      ADDR_W'(REG_WST): begin
        bus_rdata[WST_CMP_LO] = wst_q[0];
        bus_rdata[WST_CMP_HI] = wst_q[1];
        bus_rdata[WST_STEP]   = wst_q[2];
        bus_rdata[WST_CTRL]   = wst_q[3];
      end
      ADDR_W'(REG_IEN):     bus_rdata[0] = ien_q;
      ADDR_W'(REG_ISTAT):   bus_rdata[0] = flag_q;
      default:              bus_rdata = '0;
    endcase
  end

  assign irq = flag_q & ien_q;
endmodule

// File: rtl/glb_cmp_timer_chk.sv
module glb_cmp_timer_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [3:0]        wclr_bits,
  input logic [63:0]       cnt,
  input logic [63:0]       cmp,
  input logic [31:0]       step,
  input logic              run,
  input logic              auto_inc,
  input logic              hit,
  input logic              flag,
  input logic [3:0]        wst
);
  logic cnt_wr, cmp_wr;
  logic [3:0] wclr;

  assign cnt_wr = bus_we && (bus_addr == ADDR_W'(0) || bus_addr == ADDR_W'(1));
  assign cmp_wr = bus_we && (bus_addr == ADDR_W'(3) || bus_addr == ADDR_W'(4));
  assign wclr   = (bus_we && bus_addr == ADDR_W'(7)) ? wclr_bits : 4'b0;

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_ni)
    $past(run && !cnt_wr) |-> cnt == $past(cnt) + 64'd1);

  a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    $past(!run && !cnt_wr) |-> cnt == $past(cnt));

  a_r4_flag_cause: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(flag) |-> $past(hit));

  a_r5_auto_advance: assert property (@(posedge clk) disable iff (!rst_ni)
    $past(hit && auto_inc && !cmp_wr) |-> cmp == $past(cmp) + {32'd0, $past(step)});

  a_r8_wst_sticky: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |-> ((wst & $past(wst & ~wclr)) == $past(wst & ~wclr)));
endmodule

bind glb_cmp_timer glb_cmp_timer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_ni(rst_ni), .bus_addr(bus_addr), .bus_we(bus_we),
  .wclr_bits({bus_wdata[16], bus_wdata[2:0]}),
  .cnt(cnt_q), .cmp(cmp_q), .step(step_q), .run(ctrl_q.run),
  .auto_inc(ctrl_q.auto_inc), .hit(hit), .flag(flag_q), .wst(wst_q)
);

// File: tb/glb_cmp_timer_tb.sv
module glb_cmp_timer_tb;
  localparam int AW  = 4;
  localparam int ACK = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq;
  int            total = 0;
  int            bad = 0;

  always #4 clk = ~clk;

  glb_cmp_timer #(.ADDR_W(AW), .ACK_DLY(ACK)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input int a, input logic [31:0] d);
    bus_addr  = AW'(a);
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = AW'(a);
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog got=%h exp=%h", 32'd0, 32'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, lo, hi;
    int t;
    bit seen;
    idle(5);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    for (int a = 0; a < 10; a++) begin
      rd(a, v);
      chk("R1 reset word", v, 32'd0);
    end
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R3 load halves, R9 count write-done
    wr(0, 32'hFFFF_FFFE);
    wr(1, 32'h0000_0005);
    rd(0, v); chk("R3 low half", v, 32'hFFFF_FFFE);
    rd(1, v); chk("R3 high half", v, 32'h5);
    idle(ACK);
    rd(2, v); chk("R9 count wdone", v, 32'h3);
    wr(2, 32'h1);
    rd(2, v); chk("R9 clear low bit", v, 32'h2);
    wr(2, 32'h0);
    rd(2, v); chk("R9 write 0 ignored", v, 32'h2);
    wr(2, 32'h2);
    rd(2, v); chk("R9 clear high bit", v, 32'h0);

    // R2 hold while stopped
    idle(5);
    rd(0, v); chk("R2 hold stopped", v, 32'hFFFF_FFFE);

    // R2 / R10 counting with carry
    wr(6, 32'h1);
    idle(4);
    rd(0, lo); rd(1, hi);
    chk("R10 carry high", hi, 32'h6);
    chk("R2 count low", lo, 32'h2);
    wr(6, 32'h0);
    rd(0, v); chk("R2 stop edge", v, 32'h3);
    idle(3);
    rd(0, v); chk("R2 held after stop", v, 32'h3);

    // R3 priority over counting
    wr(6, 32'h1);
    wr(0, 32'h10);
    rd(0, v); chk("R3 load beats count", v, 32'h10);
    rd(1, v); chk("R3 other half kept", v, 32'h6);
    idle(2);
    rd(0, v); chk("R2 counts after load", v, 32'h12);
    wr(6, 32'h0);

    // R8 register write-done
    idle(ACK + 1);
    wr(7, 32'h0001_0007);
    wr(3, 32'h0);
    if (ACK > 1) begin
      idle(ACK - 1);
      rd(7, v); chk("R8 not yet set", v, 32'h0);
      idle(1);
    end else idle(ACK);
    rd(7, v); chk("R8 cmp low bit", v, 32'h1);
    idle(5);
    rd(7, v); chk("R8 sticky", v, 32'h1);
    wr(7, 32'h0);
    rd(7, v); chk("R8 write 0 ignored", v, 32'h1);
    wr(4, 32'h0);
    wr(5, 32'h0);
    wr(6, 32'h0);
    idle(ACK);
    rd(7, v); chk("R8 all four bits", v, 32'h0001_0007);
    wr(7, 32'h0001_0001);
    rd(7, v); chk("R8 clear ctrl and low", v, 32'h6);

    // R4 match timing
    wr(0, 32'd100); wr(1, 32'd0);
    wr(3, 32'd110); wr(4, 32'd0);
    wr(9, 32'h1);
    wr(8, 32'h1);
    wr(6, 32'h3);
    t = 0; seen = 0;
    for (int i = 1; i <= 30 && !seen; i++) begin
      @(negedge clk);
      if (irq) begin t = i; seen = 1; end
    end
    chk("R4 match delay", t, 32'd11);
    wr(6, 32'h0);
    wr(9, 32'h1);

    // R4 no flag with compare disabled
    wr(0, 32'd200); wr(3, 32'd205);
    wr(6, 32'h1);
    idle(15);
    rd(9, v); chk("R4 disabled no flag", v, 32'h0);
    wr(6, 32'h0);

    // R6 gating, R7 clear
    wr(8, 32'h0);
    wr(0, 32'd300); wr(3, 32'd302);
    wr(6, 32'h3);
    idle(5);
    wr(6, 32'h0);
    rd(9, v); chk("R4 flag set", v, 32'h1);
    chk("R6 irq masked", {31'd0, irq}, 32'd0);
    wr(8, 32'h1);
    #1 chk("R6 irq unmasked", {31'd0, irq}, 32'd1);
    wr(9, 32'h0);
    rd(9, v); chk("R7 write 0 ignored", v, 32'h1);
    wr(9, 32'h1);
    rd(9, v); chk("R7 flag cleared", v, 32'h0);
    chk("R6 irq low after clear", {31'd0, irq}, 32'd0);

    // R5 auto-advance sweep
    for (int inc = 3; inc <= 6; inc++) begin
      for (int off = 1; off <= 3; off++) begin
        wr(6, 32'h0);
        wr(9, 32'h1);
        wr(0, 32'd1000); wr(1, 32'd0);
        wr(3, 32'(1000 + off)); wr(4, 32'd0);
        wr(5, 32'(inc));
        wr(6, 32'h7);
        t = 0;
        for (int j = 0; j < 3; j++) begin
          seen = 0;
          for (int k = 0; k < 40 && !seen; k++) begin
            @(negedge clk); t++;
            if (irq) seen = 1;
          end
          chk($sformatf("R5 match %0d inc=%0d off=%0d", j, inc, off),
              t, 32'(off + 1 + inc * j));
          wr(9, 32'h1); t++;
        end
        wr(6, 32'h0);
        rd(3, v);
        chk("R5 compare advanced", v, 32'(1000 + off + 3 * inc));
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule